// File: doc/BRIEF.md
# APB Bridge to External Memory Windows with Error Reporting

The bridge is an APB slave that sits in front of several address windows, each served by an external memory agent. It decodes every APB access against the windows. For a hit it raises a one-cycle request strobe on that window and presents the word offset, the write flag and the write data. It then holds PREADY low until the agent answers with a read or a write acknowledge. Read data returned with a read acknowledge passes to PRDATA. An access that hits no window completes at once.

Each window has a build-time switch that enables error reporting. An enabled window takes a read-error and a write-error input and keeps a registered outstanding-request flag. It turns errors that pass qualification into PSLVERR for the transfer that the acknowledge completes. A read error needs the outstanding flag. A write error does not. The flag is cleared by the acknowledge that matches the window's access kind, which is read-only, write-only or read-write. A window built without error reporting never raises PSLVERR.

With the default parameters there are two windows. Window 0 starts at byte address 0x40000, holds 32768 words of 32 bits, has error reporting and is read-write. Window 1 starts at 0x60000, holds 4096 words and has no error reporting.

Top module: `apb_extmem_bridge`

## Requirements
- R1: Window 0 covers byte addresses 0x40000 to 0x5FFFF and window 1 covers 0x60000 to 0x63FFF. On the first access-phase cycle of a hit, memReq bit i of the hit window i is high for exactly one cycle. In that cycle memAddr equals (paddr - base) >> 2, memWrite equals pwrite and memWdata equals pwdata.
- R2: For a hit, PREADY stays low until the hit window returns an acknowledge, and it is high in the cycle of that acknowledge. An acknowledge in the first access cycle completes the transfer in that cycle. On a read, PRDATA equals the window's read data in the completing cycle. On a write, PRDATA is zero.
- R3: An access that hits no window has PREADY high in its first access cycle, with PRDATA zero and PSLVERR low.
- R4: The outstanding flag of an error-enabled window is 0 after reset. It sets on that window's request strobe and clears on the acknowledge that matches the window kind: read for read-only, write for write-only, either for read-write. If the strobe and a clearing acknowledge fall in the same cycle, the flag is cleared.
- R5: A read error raises PSLVERR only when the read acknowledge, the read-error input and the outstanding flag are all high in one cycle. A read answered in its own strobe cycle therefore reports no error.
- R6: A write error raises PSLVERR when the write acknowledge and the write-error input are both high, whatever the outstanding flag holds.
- R7: An access to a window without error reporting never raises PSLVERR, whatever levels its error inputs carry.
- R8: Acknowledge and error pulses that arrive with no APB access phase in progress leave PREADY and PSLVERR low and do not disturb the next transfer.
- R9: During and right after reset, with no access in progress, PREADY, PSLVERR, PRDATA and memReq are all zero. PSLVERR is never high without PREADY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write flag |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready |
| pslverr | output | 1 | APB error response |
| memReq | output | WIN_CNT | One-cycle request strobe, one bit per window |
| memAddr | output | ADDR_W-2 | Word offset inside the hit window |
| memWrite | output | 1 | Write flag to the agents |
| memWdata | output | DATA_W | Write data to the agents |
| memRdAck | input | WIN_CNT | Read acknowledge per window |
| memWrAck | input | WIN_CNT | Write acknowledge per window |
| memRdData | input | WIN_CNT x DATA_W | Read data per window |
| memRdErr | input | WIN_CNT | Read error per window, valid with its read acknowledge |
| memWrErr | input | WIN_CNT | Write error per window, valid with its write acknowledge |

## Verification
The checker watches every cycle for the following. The request strobe must be one-hot and last a single cycle. PSLVERR must never appear without PREADY or on a window without error reporting. Missed windows must complete at once. Nothing may respond while no access phase is active. The outstanding flag must follow its set and clear rules, and a read error must never appear in the strobe cycle. The bench scenarios cover what a property cannot see from the ports alone: read data and offsets for chosen values, stretched wait states of several lengths, and a write acknowledge clearing the flag so that a following same-cycle read error is dropped. They also cover stray error pulses that must leave a later clean read untouched.

// File: rtl/extmem_bridge_pkg.sv
`timescale 1ns/1ps
package extmem_bridge_pkg;
  localparam int WIN_CNT = 2;

  // access kind of a window, selects the acknowledge that clears its outstanding flag
  localparam logic [1:0] KIND_RW = 2'd0;
  localparam logic [1:0] KIND_RO = 2'd1;
  localparam logic [1:0] KIND_WO = 2'd2;

  typedef struct packed {
    logic               access;   // APB access phase active
    logic               done;     // transfer completes this cycle
    logic [WIN_CNT-1:0] inflight; // outstanding request per window
  } ctrlStrobes_t;
endpackage

// File: rtl/extmem_bridge_ctrl.sv
`timescale 1ns/1ps
module extmem_bridge_ctrl
  import extmem_bridge_pkg::*;
#(
  parameter logic [WIN_CNT-1:0]      WIN_ERR_EN = 2'b01,
  parameter logic [WIN_CNT-1:0][1:0] WIN_KIND   = {KIND_RW, KIND_RW}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic [WIN_CNT-1:0] winHit,
  input  logic               noHit,
  input  logic [WIN_CNT-1:0] memRdAck,
  input  logic [WIN_CNT-1:0] memWrAck,
  output logic [WIN_CNT-1:0] memReq,
  output ctrlStrobes_t       ctrl
);
  logic busy;
  logic accessPhase;
  logic decodeStrb;
  logic selAck;
  logic xferDone;
  logic [WIN_CNT-1:0] inflight;

  assign accessPhase = psel & penable;
  assign decodeStrb  = accessPhase & ~busy;
  assign memReq      = winHit & {WIN_CNT{decodeStrb}};
  assign selAck      = |(winHit & (memRdAck | memWrAck));
  assign xferDone    = accessPhase & (noHit | selAck);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (xferDone) begin
      busy <= 1'b0;
    end else if (decodeStrb) begin
      busy <= 1'b1;
    end
  end

  for (genvar i = 0; i < WIN_CNT; i++) begin : g_win
    if (WIN_ERR_EN[i]) begin : g_track
      logic clrAck;
      if (WIN_KIND[i] == KIND_RO) begin : g_ro
        assign clrAck = memRdAck[i];
      end else if (WIN_KIND[i] == KIND_WO) begin : g_wo
        assign clrAck = memWrAck[i];
      end else begin : g_rw
        assign clrAck = memRdAck[i] | memWrAck[i];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          inflight[i] <= 1'b0;
        end else if (clrAck) begin
          inflight[i] <= 1'b0;
        end else if (memReq[i]) begin
          inflight[i] <= 1'b1;
        end
      end
    end else begin : g_none
      assign inflight[i] = 1'b0;
    end
  end

  always_comb begin
    ctrl          = '0;
    ctrl.access   = accessPhase;
    ctrl.done     = xferDone;
    ctrl.inflight = inflight;
  end
endmodule

// File: rtl/extmem_bridge_datapath.sv
`timescale 1ns/1ps
module extmem_bridge_datapath
  import extmem_bridge_pkg::*;
#(
  parameter int                              ADDR_W         = 20,
  parameter int                              DATA_W         = 32,
  parameter logic [WIN_CNT-1:0][ADDR_W-1:0]  WIN_BASE       = {20'h60000, 20'h40000},
  parameter logic [WIN_CNT-1:0][4:0]         WIN_WORDS_LOG2 = {5'd12, 5'd15},
  parameter logic [WIN_CNT-1:0]              WIN_ERR_EN     = 2'b01
) (
  input  logic [ADDR_W-1:0]              paddr,
  input  logic                           pwrite,
  input  logic [DATA_W-1:0]              pwdata,
  input  ctrlStrobes_t                   ctrl,
  input  logic [WIN_CNT-1:0]             memRdAck,
  input  logic [WIN_CNT-1:0]             memWrAck,
  input  logic [WIN_CNT-1:0][DATA_W-1:0] memRdData,
  input  logic [WIN_CNT-1:0]             memRdErr,
  input  logic [WIN_CNT-1:0]             memWrErr,
  output logic [WIN_CNT-1:0]             winHit,
  output logic                           noHit,
  output logic [ADDR_W-3:0]              memAddr,
  output logic                           memWrite,
  output logic [DATA_W-1:0]              memWdata,
  output logic [DATA_W-1:0]              prdata,
  output logic                           pready,
  output logic                           pslverr
);
  localparam int OFF_W = ADDR_W - 2;

  logic [WIN_CNT-1:0][OFF_W-1:0] winOff;
  logic [WIN_CNT-1:0]            rdQual;
  logic [WIN_CNT-1:0]            wrQual;

  for (genvar i = 0; i < WIN_CNT; i++) begin : g_win
    localparam int SPAN_LOG2 = int'(WIN_WORDS_LOG2[i]) + 2;
    logic [ADDR_W-1:0] byteOff;

    assign byteOff   = paddr - WIN_BASE[i];
    assign winHit[i] = (paddr >= WIN_BASE[i]) && ((byteOff >> SPAN_LOG2) == '0);
    assign winOff[i] = byteOff[ADDR_W-1:2];

    if (WIN_ERR_EN[i]) begin : g_err
      assign rdQual[i] = memRdAck[i] & memRdErr[i] & ctrl.inflight[i];
      assign wrQual[i] = memWrAck[i] & memWrErr[i];
    end else begin : g_noerr
      assign rdQual[i] = 1'b0;
      assign wrQual[i] = 1'b0;
    end
  end

  assign noHit = ~|winHit;

  always_comb begin
    logic [DATA_W-1:0] rdSel;
    memAddr = '0;
    rdSel   = '0;
    for (int i = 0; i < WIN_CNT; i++) begin
      if (winHit[i]) begin
        memAddr = memAddr | winOff[i];
        rdSel   = rdSel | memRdData[i];
      end
    end
    prdata = (ctrl.done && !pwrite) ? rdSel : '0;
  end

  assign memWrite = pwrite;
  assign memWdata = pwdata;
  assign pready   = ctrl.done;
  assign pslverr  = ctrl.done & |(winHit & (rdQual | wrQual));
endmodule

// File: rtl/apb_extmem_bridge.sv
`timescale 1ns/1ps
module apb_extmem_bridge
  import extmem_bridge_pkg::*;
#(
  parameter int                              ADDR_W         = 20,
  parameter int                              DATA_W         = 32,
  parameter logic [WIN_CNT-1:0][ADDR_W-1:0]  WIN_BASE       = {20'h60000, 20'h40000},
  parameter logic [WIN_CNT-1:0][4:0]         WIN_WORDS_LOG2 = {5'd12, 5'd15},
  parameter logic [WIN_CNT-1:0]              WIN_ERR_EN     = 2'b01,
  parameter logic [WIN_CNT-1:0][1:0]         WIN_KIND       = {KIND_RW, KIND_RW}
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           psel,
  input  logic                           penable,
  input  logic                           pwrite,
  input  logic [ADDR_W-1:0]              paddr,
  input  logic [DATA_W-1:0]              pwdata,
  output logic [DATA_W-1:0]              prdata,
  output logic                           pready,
  output logic                           pslverr,
  output logic [WIN_CNT-1:0]             memReq,
  output logic [ADDR_W-3:0]              memAddr,
  output logic                           memWrite,
  output logic [DATA_W-1:0]              memWdata,
  input  logic [WIN_CNT-1:0]             memRdAck,
  input  logic [WIN_CNT-1:0]             memWrAck,
  input  logic [WIN_CNT-1:0][DATA_W-1:0] memRdData,
  input  logic [WIN_CNT-1:0]             memRdErr,
  input  logic [WIN_CNT-1:0]             memWrErr
);
  ctrlStrobes_t       ctrlBus;
  logic [WIN_CNT-1:0] winHit;
  logic               noHit;

  extmem_bridge_ctrl #(
    .WIN_ERR_EN (WIN_ERR_EN),
    .WIN_KIND   (WIN_KIND)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .winHit   (winHit),
    .noHit    (noHit),
    .memRdAck (memRdAck),
    .memWrAck (memWrAck),
    .memReq   (memReq),
    .ctrl     (ctrlBus)
  );

  extmem_bridge_datapath #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .WIN_BASE       (WIN_BASE),
    .WIN_WORDS_LOG2 (WIN_WORDS_LOG2),
    .WIN_ERR_EN     (WIN_ERR_EN)
  ) i_datapath (
    .paddr     (paddr),
    .pwrite    (pwrite),
    .pwdata    (pwdata),
    .ctrl      (ctrlBus),
    .memRdAck  (memRdAck),
    .memWrAck  (memWrAck),
    .memRdData (memRdData),
    .memRdErr  (memRdErr),
    .memWrErr  (memWrErr),
    .winHit    (winHit),
    .noHit     (noHit),
    .memAddr   (memAddr),
    .memWrite  (memWrite),
    .memWdata  (memWdata),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr)
  );
endmodule

// File: rtl/apb_extmem_bridge_chk.sv
`timescale 1ns/1ps
module apb_extmem_bridge_chk
  import extmem_bridge_pkg::*;
#(
  parameter int                              ADDR_W         = 20,
  parameter int                              DATA_W         = 32,
  parameter logic [WIN_CNT-1:0][ADDR_W-1:0]  WIN_BASE       = {20'h60000, 20'h40000},
  parameter logic [WIN_CNT-1:0][4:0]         WIN_WORDS_LOG2 = {5'd12, 5'd15},
  parameter logic [WIN_CNT-1:0]              WIN_ERR_EN     = 2'b01,
  parameter logic [WIN_CNT-1:0][1:0]         WIN_KIND       = {KIND_RW, KIND_RW}
) (
  input logic               clk,
  input logic               rst,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [DATA_W-1:0]  prdata,
  input logic               pready,
  input logic               pslverr,
  input logic [WIN_CNT-1:0] memReq,
  input logic [WIN_CNT-1:0] memRdAck,
  input logic [WIN_CNT-1:0] memWrAck,
  input logic [WIN_CNT-1:0] inflight
);
  logic [WIN_CNT-1:0] inWin;
  logic               act;

  assign act = psel && penable;

  for (genvar i = 0; i < WIN_CNT; i++) begin : g_win
    localparam int SPAN_LOG2 = int'(WIN_WORDS_LOG2[i]) + 2;
    logic [ADDR_W-1:0] rel;
    logic              kindAck;

    assign rel      = paddr - WIN_BASE[i];
    assign inWin[i] = (paddr >= WIN_BASE[i]) && ((rel >> SPAN_LOG2) == '0);
    assign kindAck  = (WIN_KIND[i] == KIND_RO) ? memRdAck[i] :
                      (WIN_KIND[i] == KIND_WO) ? memWrAck[i] :
                      (memRdAck[i] | memWrAck[i]);

    if (WIN_ERR_EN[i]) begin : g_err
      AST_INFLIGHT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        kindAck |=> !inflight[i]); // R4
      AST_INFLIGHT_SET: assert property (@(posedge clk) disable iff (rst)
        (memReq[i] && !kindAck) |=> inflight[i]); // R4
    end else begin : g_plain
      AST_PLAIN_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (act && inWin[i]) |-> !pslverr); // R7
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(memReq)); // R1
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (|memReq) |=> !(|memReq)); // R1
  AST_WAIT_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (act && |inWin && !(|(inWin & (memRdAck | memWrAck)))) |-> !pready); // R2
  AST_MISS_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (act && !(|inWin)) |-> (pready && !pslverr && prdata == '0)); // R3
  AST_RDERR_NOT_FRESH: assert property (@(posedge clk) disable iff (rst)
    (pslverr && !pwrite) |-> !(|memReq)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !act |-> (!pready && !pslverr && memReq == '0)); // R8
  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> pready); // R9
endmodule

bind apb_extmem_bridge apb_extmem_bridge_chk #(
  .ADDR_W         (ADDR_W),
  .DATA_W         (DATA_W),
  .WIN_BASE       (WIN_BASE),
  .WIN_WORDS_LOG2 (WIN_WORDS_LOG2),
  .WIN_ERR_EN     (WIN_ERR_EN),
  .WIN_KIND       (WIN_KIND)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .prdata   (prdata),
  .pready   (pready),
  .pslverr  (pslverr),
  .memReq   (memReq),
  .memRdAck (memRdAck),
  .memWrAck (memWrAck),
  .inflight (ctrlBus.inflight)
);

// File: tb/test_apb_extmem_bridge.sv
`timescale 1ns/1ps
module test_apb_extmem_bridge;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int NW     = 2;
  localparam real HALF  = 4.0;

  typedef struct packed {
    logic [19:0] addr;
    logic        wr;
    logic [31:0] data;
    logic [2:0]  lat;
    logic        rdErr;
    logic        wrErr;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{20'h40010, 1'b0, 32'hA5A50001, 3'd2, 1'b0, 1'b0, 1'b0},
    '{20'h40020, 1'b0, 32'h12345678, 3'd1, 1'b1, 1'b0, 1'b1},
    '{20'h5FFFC, 1'b1, 32'hDEADBEEF, 3'd3, 1'b0, 1'b1, 1'b1},
    '{20'h40004, 1'b0, 32'hCAFE0004, 3'd0, 1'b1, 1'b1, 1'b0},
    '{20'h40000, 1'b1, 32'h0BADF00D, 3'd0, 1'b0, 1'b1, 1'b1},
    '{20'h40008, 1'b0, 32'h55AA55AA, 3'd1, 1'b0, 1'b1, 1'b0},
    '{20'h60008, 1'b0, 32'h77778888, 3'd2, 1'b1, 1'b1, 1'b0},
    '{20'h60010, 1'b1, 32'h11112222, 3'd1, 1'b1, 1'b1, 1'b0},
    '{20'h63FFC, 1'b0, 32'h0F0F0F0F, 3'd1, 1'b0, 1'b0, 1'b0},
    '{20'h70000, 1'b0, 32'h99999999, 3'd0, 1'b1, 1'b0, 1'b0},
    '{20'h3FFFC, 1'b0, 32'h88888888, 3'd0, 1'b1, 1'b0, 1'b0},
    '{20'h64000, 1'b1, 32'h66666666, 3'd0, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst;
  logic psel, penable, pwrite;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pwdata, prdata, memWdata;
  logic pready, pslverr, memWrite;
  logic [NW-1:0] memReq, memRdAck, memWrAck, memRdErr, memWrErr;
  logic [ADDR_W-3:0] memAddr;
  logic [NW-1:0][DATA_W-1:0] memRdData;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #(HALF) clk = ~clk;

  apb_extmem_bridge i_apb_extmem_bridge (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .memReq(memReq), .memAddr(memAddr), .memWrite(memWrite),
    .memWdata(memWdata), .memRdAck(memRdAck), .memWrAck(memWrAck),
    .memRdData(memRdData), .memRdErr(memRdErr), .memWrErr(memWrErr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    memRdAck = '0; memWrAck = '0; memRdErr = '0; memWrErr = '0; memRdData = '0;
  endtask

  // one APB transfer with a modelled external agent answering after lat cycles
  task automatic xfer(input vec_t v);
    int idx;
    logic [19:0] base;
    string errTag;
    idx = -1; base = '0;
    if (v.addr >= 20'h40000 && v.addr < 20'h60000) begin idx = 0; base = 20'h40000; end
    else if (v.addr >= 20'h60000 && v.addr < 20'h64000) begin idx = 1; base = 20'h60000; end
    errTag = (idx == 1) ? "R7" : (idx < 0) ? "R3" : v.wr ? "R6" : "R5";

    @(negedge clk);
    psel = 1'b1; penable = 1'b0; paddr = v.addr; pwrite = v.wr; pwdata = v.data;
    @(negedge clk);
    penable = 1'b1;
    if (idx >= 0 && v.lat == 0) raise(idx, v);
    #1;
    check("R1 memReq strobe", 32'(memReq), (idx >= 0) ? 32'(1 << idx) : 32'd0);
    if (idx >= 0) begin
      check("R1 memAddr", 32'(memAddr), 32'((v.addr - base) >> 2));
      check("R1 memWrite", 32'(memWrite), 32'(v.wr));
      check("R1 memWdata", memWdata, v.data);
      if (v.lat != 0) check("R2 wait pready", 32'(pready), 32'd0);
      for (int k = 1; k <= int'(v.lat); k++) begin
        @(negedge clk);
        if (k == int'(v.lat)) raise(idx, v);
        #1;
        check("R1 strobe single", 32'(memReq), 32'd0);
        if (k < int'(v.lat)) check("R2 wait pready", 32'(pready), 32'd0);
      end
    end
    check("R2 pready done", 32'(pready), 32'd1);
    check(errTag, 32'(pslverr), 32'(v.expErr));
    check((idx < 0) ? "R3 prdata" : "R2 prdata", prdata,
          (idx >= 0 && !v.wr) ? v.data : 32'd0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    quiet();
  endtask

  task automatic raise(input int idx, input vec_t v);
    if (v.wr) memWrAck[idx] = 1'b1;
    else      memRdAck[idx] = 1'b1;
    memRdData[idx] = v.data;
    memRdErr[idx]  = v.rdErr;
    memWrErr[idx]  = v.wrErr;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2.0 * 20000.0);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst = 1'b1; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    quiet();
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset pready", 32'(pready), 32'd0);
    check("R9 reset pslverr", 32'(pslverr), 32'd0);
    check("R9 reset prdata", prdata, 32'd0);
    check("R9 reset memReq", 32'(memReq), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle after reset", 32'({pready, pslverr, memReq}), 32'd0);

    // table: read/write, errors, wait lengths, window edges, misses
    // entry 3 needs the write ack of entry 2 to have cleared the flag (R4)
    for (int n = 0; n < NVEC; n++) xfer(VEC[n]);

    // R8: stray read ack with error while idle, then a clean read
    @(negedge clk);
    memRdAck[0] = 1'b1; memRdErr[0] = 1'b1; memWrAck[1] = 1'b1; memWrErr[1] = 1'b1;
    #1;
    check("R8 stray pslverr", 32'(pslverr), 32'd0);
    check("R8 stray pready", 32'(pready), 32'd0);
    @(negedge clk);
    quiet();
    xfer('{20'h40100, 1'b0, 32'h3C3C3C3C, 3'd2, 1'b0, 1'b0, 1'b0});

    // R5: read error raised on a non-acknowledge cycle is not sampled
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; paddr = 20'h40200; pwrite = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    memRdErr[0] = 1'b1;
    #1;
    check("R5 err without ack", 32'({pready, pslverr}), 32'd0);
    @(negedge clk);
    memRdErr[0] = 1'b0; memRdAck[0] = 1'b1; memRdData[0] = 32'h0000ABCD;
    #1;
    check("R5 clean completion", 32'({pready, pslverr}), 32'b10);
    check("R2 prdata late", prdata, 32'h0000ABCD);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; quiet();

    // R4: reset in mid-transfer leaves no stale flag; a same-cycle read error then stays silent
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; paddr = 20'h40300; pwrite = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    rst = 1'b1; psel = 1'b0; penable = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    xfer('{20'h40304, 1'b0, 32'h5A5A0000, 3'd0, 1'b1, 1'b0, 1'b0});

    repeat (2) @(negedge clk);
    summary();
  end
endmodule